// File: doc/BRIEF.md
# SerDes Operating-Mode and Direction Controller

This block turns the static control pins of a 12-bit serializer/deserializer into the enables, pad output-enables and reset that the rest of the device runs on. A two-bit mode select gives either power-down or one of three operating bands. The three bands differ only in the reference-clock frequency range the analog side accepts, so their digital behaviour is the same. A direction pin picks serializer or deserializer. A multiplier select picks standard or overclocked bit timing, and it matters only while serializing.

Power-down acts as the device reset. It forces every pad driver off, clears the parallel output register and arms reference-loss detection. Once the mode pins leave power-down, the internal reset is released synchronously. The mode pins are brought into the clock domain through a two-flop synchronizer. The "PLL ready" flag, and with it the serializer and deserializer enables, rises only after the reference has been seen present for a set number of cycles. The direction pin is also sent back out inverted, with no clocking, so that two devices can be chained. When the direction changes, the deserializer's parallel output register keeps its last word.

Top module: `serdes_mode_unit`

## Requirements
- R1: While `modeSel` is 2'b00, the following hold with no clock edge needed: `pdReset` is 1; `parOe`, `serOe`, `serEn`, `desEn`, `ovclkSel` and `pllReady` are 0; `modeStatus` is 2'b00; `parOut` is all zeros.
- R2: When `modeSel` leaves 2'b00, `pdReset` is still 1 after the first rising clock edge and is 0 after the second.
- R3: The mode values 2'b01, 2'b10 and 2'b11 give the same outputs for the same direction, multiplier and reference inputs.
- R4: With `dirIn`=1 (serializer) and not powered down, `serOe`=1 and `parOe`=0. With `dirIn`=0 (deserializer), `parOe`=1 and `serOe`=0. `serEn` and `desEn` follow the same direction and are 1 only while `pllReady` is 1.
- R5: `dirOut` is always the inverse of `dirIn`, combinationally, in power-down as well.
- R6: In serializer mode, `mulSel`=1 gives `ovclkSel`=0 and `modeStatus`=2'b01, and `mulSel`=0 gives `ovclkSel`=1 and `modeStatus`=2'b10. In deserializer mode, `ovclkSel`=0 and `modeStatus`=2'b11 whatever `mulSel` is.
- R7: `pllReady` rises only after REF_GOOD consecutive clock cycles in which the synchronized `refLost` is 0 and reset is released: 6 edges after the input falls, or after the mode leaves power-down, with the defaults. It falls 3 edges after `refLost` rises.
- R8: `parOut` loads `rxWord` on a rising edge where `desEn` and `rxWordValid` are both 1. At every other edge it holds, in serializer mode too.
- R9: A change of `dirIn` or `mulSel` shows on the outputs after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| modeSel | input | 2 | Mode select; 2'b00 is power-down |
| dirIn | input | 1 | Direction: 1 serializer, 0 deserializer |
| mulSel | input | 1 | 1 standard clocking, 0 overclocked |
| refLost | input | 1 | 1 when the reference clock is absent |
| rxWordValid | input | 1 | Deserialized word available |
| rxWord | input | DATA_W | Deserialized word |
| dirOut | output | 1 | Inverted direction, for a partner device |
| serEn | output | 1 | Serializer enable |
| desEn | output | 1 | Deserializer enable |
| ovclkSel | output | 1 | Overclocked timing select |
| pdReset | output | 1 | Internal reset, active high |
| pllReady | output | 1 | Reference seen stable |
| parOe | output | 1 | Parallel pad output enable |
| serOe | output | 1 | Serial pad output enable |
| parOut | output | DATA_W | Parallel output register |
| modeStatus | output | 2 | 00 off, 01 serializer, 10 overclocked serializer, 11 deserializer |

## Verification
The bench uses the default parameters: a 12-bit word, two synchronizer stages and a reference-good count of 4. With these values the release, readiness and direction-change latencies are short enough to check at the exact edge on which each output changes, and to confirm that it has not changed one edge earlier. The 12-bit word makes it possible to show a captured value surviving a trip through serializer mode with a different word on the input. The short ready count lets the bench drop and restore the reference several times in one run.

// File: rtl/serdes_mode_pkg.sv
package serdes_mode_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'b00,
    ST_SER    = 2'b01,
    ST_SER_OC = 2'b10,
    ST_DES    = 2'b11
  } modeStat_t;

  // Strobes from control to the datapath
  typedef struct packed {
    logic serEn;
    logic desEn;
    logic ovclkSel;
    logic parOe;
    logic serOe;
  } ctrlStrb_t;

endpackage

// File: rtl/serdes_sync.sv
module serdes_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= RST_VAL;
        else      chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= {STAGES{RST_VAL}};
        else      chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl
  import serdes_mode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REF_GOOD = 4
) (
  input  logic       clk,
  input  logic [1:0] modeSel,
  input  logic       dirIn,
  input  logic       mulSel,
  input  logic       refLost,
  output ctrlStrb_t  strb,
  output logic       pdReset,
  output logic       pllReady,
  output logic [1:0] modeStatus
);

  localparam int unsigned CNT_W = $clog2(REF_GOOD + 1);
  localparam int unsigned PIN_W = 5;

  logic pdAsync;
  logic rstDone;
  logic [PIN_W-1:0] pinSync;
  logic [1:0] syncMode;
  logic syncDir, syncMul, syncLost;
  logic running;
  logic [CNT_W-1:0] refCnt;
  modeStat_t statNext;

  assign pdAsync = (modeSel == 2'b00);

  // Reset: asserted at once, released through the synchronizer chain
  serdes_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rstSync (
    .clk(clk), .arst(pdAsync), .din(1'b1), .dout(rstDone)
  );

  // Pins brought into the clock domain; the reference reads as lost while in reset
  serdes_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b00001)) u_pinSync (
    .clk(clk), .arst(pdAsync), .din({modeSel, dirIn, mulSel, refLost}), .dout(pinSync)
  );

  assign pdReset = ~rstDone;
  assign {syncMode, syncDir, syncMul, syncLost} = pinSync;
  assign running = !pdReset && (syncMode != 2'b00);

  // Reference-good qualification
  always_ff @(posedge clk or posedge pdReset) begin
    if (pdReset)                         refCnt <= '0;
    else if (syncLost)                   refCnt <= '0;
    else if (refCnt != CNT_W'(REF_GOOD)) refCnt <= refCnt + 1'b1;
  end

  assign pllReady = running && (refCnt == CNT_W'(REF_GOOD));

  always_comb begin
    strb.serEn    = running && syncDir && pllReady;
    strb.desEn    = running && !syncDir && pllReady;
    strb.ovclkSel = running && syncDir && !syncMul;
    strb.parOe    = running && !syncDir;
    strb.serOe    = running && syncDir;
    if (!running)     statNext = ST_OFF;
    else if (!syncDir) statNext = ST_DES;
    else if (syncMul)  statNext = ST_SER;
    else               statNext = ST_SER_OC;
  end

  assign modeStatus = statNext;

  AST_PD_HIZ: assert property (@(posedge clk) pdReset |-> !strb.parOe && !strb.serOe && !pllReady); // R1
  AST_EN_NEEDS_READY: assert property (@(posedge clk) disable iff (pdReset)
    (strb.serEn || strb.desEn) |-> pllReady); // R4
  AST_EN_EXCL: assert property (@(posedge clk) disable iff (pdReset)
    $onehot0({strb.serEn, strb.desEn})); // R4
  AST_OVCLK_SER: assert property (@(posedge clk) disable iff (pdReset)
    strb.ovclkSel |-> strb.serOe && modeStatus == 2'b10); // R6
  AST_READY_AFTER_REF: assert property (@(posedge clk) disable iff (pdReset)
    $rose(pllReady) |-> !$past(syncLost)); // R7
  AST_LOST_DROPS: assert property (@(posedge clk) disable iff (pdReset)
    syncLost |=> !pllReady); // R7

endmodule

// File: rtl/serdes_mode_dp.sv
module serdes_mode_dp
  import serdes_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              pdReset,
  input  ctrlStrb_t         strb,
  input  logic              rxWordValid,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] parOut,
  output logic              serEn,
  output logic              desEn,
  output logic              ovclkSel,
  output logic              parOe,
  output logic              serOe
);

  logic capture;

  assign capture = strb.desEn && rxWordValid;

  // Parallel output register: cleared in power-down, otherwise held unless written
  always_ff @(posedge clk or posedge pdReset) begin
    if (pdReset)      parOut <= '0;
    else if (capture) parOut <= rxWord;
  end

  assign serEn    = strb.serEn;
  assign desEn    = strb.desEn;
  assign ovclkSel = strb.ovclkSel;
  assign parOe    = strb.parOe;
  assign serOe    = strb.serOe;

  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (pdReset)
    !capture |=> $stable(parOut)); // R8
  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (pdReset)
    capture |=> parOut == $past(rxWord)); // R8

endmodule

// File: rtl/serdes_mode_unit.sv
module serdes_mode_unit
  import serdes_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REF_GOOD = 4
) (
  input  logic              clk,
  input  logic [1:0]        modeSel,
  input  logic              dirIn,
  input  logic              mulSel,
  input  logic              refLost,
  input  logic              rxWordValid,
  input  logic [DATA_W-1:0] rxWord,
  output logic              dirOut,
  output logic              serEn,
  output logic              desEn,
  output logic              ovclkSel,
  output logic              pdReset,
  output logic              pllReady,
  output logic              parOe,
  output logic              serOe,
  output logic [DATA_W-1:0] parOut,
  output logic [1:0]        modeStatus
);

  ctrlStrb_t strb;

  assign dirOut = ~dirIn;

  serdes_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES), .REF_GOOD(REF_GOOD)) u_ctrl (
    .clk(clk), .modeSel(modeSel), .dirIn(dirIn), .mulSel(mulSel), .refLost(refLost),
    .strb(strb), .pdReset(pdReset), .pllReady(pllReady), .modeStatus(modeStatus)
  );

  serdes_mode_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .pdReset(pdReset), .strb(strb), .rxWordValid(rxWordValid), .rxWord(rxWord),
    .parOut(parOut), .serEn(serEn), .desEn(desEn), .ovclkSel(ovclkSel),
    .parOe(parOe), .serOe(serOe)
  );

endmodule

// File: tb/serdes_mode_unit_bench.sv
module serdes_mode_unit_bench;

  localparam int unsigned DATA_W = 12;

  logic clk = 1'b0;
  logic [1:0] modeSel;
  logic dirIn, mulSel, refLost, rxWordValid;
  logic [DATA_W-1:0] rxWord;
  logic dirOut, serEn, desEn, ovclkSel, pdReset, pllReady, parOe, serOe;
  logic [DATA_W-1:0] parOut;
  logic [1:0] modeStatus;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serdes_mode_unit u_serdes_mode_unit (
    .clk(clk), .modeSel(modeSel), .dirIn(dirIn), .mulSel(mulSel), .refLost(refLost),
    .rxWordValid(rxWordValid), .rxWord(rxWord), .dirOut(dirOut), .serEn(serEn),
    .desEn(desEn), .ovclkSel(ovclkSel), .pdReset(pdReset), .pllReady(pllReady),
    .parOe(parOe), .serOe(serOe), .parOut(parOut), .modeStatus(modeStatus)
  );

  typedef struct packed {
    logic [1:0] ms;
    logic dir;
    logic mul;
    logic ser;
    logic des;
    logic ov;
    logic pOe;
    logic sOe;
    logic [1:0] st;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01},
    '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10},
    '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11},
    '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11},
    '{2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10},
    '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
    '{2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11},
    '{2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // advance n rising edges and sit mid-cycle
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modeSel = 2'b00; dirIn = 1'b0; mulSel = 1'b1; refLost = 1'b0;
    rxWordValid = 1'b0; rxWord = '0;
    tick(3);
    // R1 reset state
    chk("R1", "pdReset", pdReset, 1);
    chk("R1", "oe", {parOe, serOe}, 0);
    chk("R1", "en", {serEn, desEn, ovclkSel, pllReady}, 0);
    chk("R1", "status", modeStatus, 2'b00);
    chk("R1", "parOut", parOut, 0);

    // Table walk: R3 R4 R6 across bands and directions
    for (int i = 0; i < NVEC; i++) begin
      modeSel = VECS[i].ms; dirIn = VECS[i].dir; mulSel = VECS[i].mul;
      tick(12);
      chk("R4", $sformatf("vec%0d serEn", i), serEn, VECS[i].ser);
      chk("R4", $sformatf("vec%0d desEn", i), desEn, VECS[i].des);
      chk("R6", $sformatf("vec%0d ovclk", i), ovclkSel, VECS[i].ov);
      chk("R4", $sformatf("vec%0d parOe", i), parOe, VECS[i].pOe);
      chk("R4", $sformatf("vec%0d serOe", i), serOe, VECS[i].sOe);
      chk("R3", $sformatf("vec%0d status", i), modeStatus, VECS[i].st);
    end

    // R2 release timing and R7 readiness after leaving power-down
    modeSel = 2'b01; dirIn = 1'b1; mulSel = 1'b1;
    tick(1);
    chk("R2", "pdReset after 1 edge", pdReset, 1);
    tick(1);
    chk("R2", "pdReset after 2 edges", pdReset, 0);
    chk("R9", "status after release", modeStatus, 2'b01);
    tick(3);
    chk("R7", "pllReady after 5 edges", pllReady, 0);
    chk("R4", "serEn before ready", serEn, 0);
    tick(1);
    chk("R7", "pllReady after 6 edges", pllReady, 1);
    chk("R4", "serEn when ready", serEn, 1);

    // R7 loss of reference and recovery
    refLost = 1'b1;
    tick(2);
    chk("R7", "ready 2 edges after loss", pllReady, 1);
    tick(1);
    chk("R7", "ready 3 edges after loss", pllReady, 0);
    chk("R4", "serEn without ready", serEn, 0);
    refLost = 1'b0;
    tick(5);
    chk("R7", "ready 5 edges after return", pllReady, 0);
    tick(1);
    chk("R7", "ready 6 edges after return", pllReady, 1);

    // R9 direction change latency
    dirIn = 1'b0;
    tick(1);
    chk("R9", "status 1 edge after dir", modeStatus, 2'b01);
    chk("R9", "parOe 1 edge after dir", parOe, 0);
    tick(1);
    chk("R9", "status 2 edges after dir", modeStatus, 2'b11);
    chk("R9", "desEn 2 edges after dir", desEn, 1);

    // R8 capture and hold
    rxWord = 12'hA5C; rxWordValid = 1'b1;
    tick(1);
    chk("R8", "parOut loaded", parOut, 12'hA5C);
    rxWordValid = 1'b0; rxWord = 12'h000;
    tick(2);
    chk("R8", "parOut held no valid", parOut, 12'hA5C);
    dirIn = 1'b1;
    tick(3);
    rxWord = 12'h3C3; rxWordValid = 1'b1;
    tick(2);
    chk("R8", "parOut held in serializer", parOut, 12'hA5C);
    rxWordValid = 1'b0;
    dirIn = 1'b0;
    tick(3);
    chk("R8", "parOut held back in deser", parOut, 12'hA5C);
    rxWord = 12'h5A1; rxWordValid = 1'b1;
    tick(1);
    chk("R8", "parOut new word", parOut, 12'h5A1);
    rxWordValid = 1'b0;

    // R6 mulSel ignored in deserializer
    mulSel = 1'b0;
    tick(3);
    chk("R6", "ovclk in deser", ovclkSel, 0);
    chk("R6", "status in deser", modeStatus, 2'b11);

    // R5 inverted direction
    dirIn = 1'b1; #1;
    chk("R5", "dirOut running", dirOut, 0);
    dirIn = 1'b0; #1;
    chk("R5", "dirOut running", dirOut, 1);

    // R1 asynchronous power-down mid-cycle
    tick(1);
    modeSel = 2'b00; #1;
    chk("R1", "pdReset async", pdReset, 1);
    chk("R1", "oe async", {parOe, serOe}, 0);
    chk("R1", "status async", modeStatus, 2'b00);
    chk("R1", "parOut async clear", parOut, 0);
    chk("R1", "desEn async", desEn, 0);
    dirIn = 1'b1; #1;
    chk("R5", "dirOut in power-down", dirOut, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule